// File: doc/BRIEF.md
# Main Clock Frequency Counter

This block estimates the frequency of a fast main clock by comparing it with a slow reference clock of known frequency. It counts main-clock cycles across a window of a fixed number of slow-clock periods, which is sixteen by default. The result appears in a status word: a saturating count in the low bits and a ready flag directly above them. Software can read the status word at any time. Dividing the count by the window length and multiplying by the reference frequency gives the main frequency. For example, a 12 MHz main clock against a 32.768 kHz reference gives a count of about 5859, and an 84 MHz clock gives about 41016.

The measurement is single-shot. It runs only when a clock-change pulse arrives on `clk_change`, which is synchronous to the main clock. When the window closes, the result stays frozen until the next change pulse. The slow clock is not used as a clock. It is sampled as data in the main domain through a synchronizer, and its synchronized rising edges open the window, count periods and close the window.

The controller has three states. `ST_IDLE` holds the last result. `ST_ARM` waits for the first synchronized slow rising edge. `ST_COUNT` counts main cycles and slow edges. The transitions are:
- *start*: `ST_IDLE` to `ST_ARM` on a change pulse.
- *open*: `ST_ARM` to `ST_COUNT` on a synchronized slow rise when no change pulse is present.
- *close*: `ST_COUNT` to `ST_IDLE` on the slow rise that completes the window.
- *restart*: `ST_ARM` or `ST_COUNT` back to `ST_ARM` on a change pulse. A change pulse has priority over a slow edge in the same cycle.

Top module: `mfc_meter`

## Requirements
- R1: While reset is asserted and after it is released, `status` is all zeros and no measurement is in progress.
- R2: A completed measurement reports, within ±1, the number of main-clock cycles spanning 16 slow-clock periods. The window opens on a synchronized slow rising edge and closes on the 16th one after it.
- R3: Bit 16 of `status` is the ready flag. It is set in the cycle the window closes, and bits 15:0 then hold the count.
- R4: In the main-clock cycle after a `clk_change` pulse, the ready flag reads 0 and the controller is in `ST_ARM`.
- R5: Bits 15:0 of `status` keep their previous value until a new measurement completes. The new count and the ready flag appear in the same cycle.
- R6: After a measurement completes, no further measurement starts without a new `clk_change` pulse, and `status` stays unchanged however many slow periods pass.
- R7: A `clk_change` pulse during `ST_ARM` or `ST_COUNT` abandons the current window. The next result then covers a full window that opens after that pulse, so ready cannot rise sooner than 16 slow periods after it.
- R8: If the main clock makes more cycles in the window than bits 15:0 can hold, the count stops at 0xFFFF instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock being measured; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow reference clock, sampled as data |
| clk_change | input | 1 | One-cycle pulse: main clock source has changed, start a measurement |
| status | output | 17 | Bit 16 ready flag, bits 15:0 cycle count |

## Verification
The bench sweeps the ratio of slow to main period over whole-number ratios, a fractional ratio and large ratios. This separates an off-by-one in the window length, which scales with the ratio, from an error in synchronizer quantization, which stays at one cycle. Consecutive ratios differ, so a count that is published late or is stale shows up in the first sample where ready is set. A second change pulse in the middle of a window tells a true restart apart from a window that simply continues. A ratio above 4096 separates saturation from wrap-around. Repeated reads across many idle slow periods show that the measurement is single-shot.

// File: rtl/mfc_pkg.sv
`timescale 1ns/1ps
package mfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } mfc_state_e;
endpackage

// File: rtl/mfc_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the slow reference with rising-edge detect.
module mfc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[DEPTH-2:0], async_in};
        end
    end

    // shreg[STAGES-1] is the synchronized level; shreg[STAGES] is its previous value
    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/mfc_cycle_cnt.sv
`timescale 1ns/1ps
// Saturating main-cycle counter for the measurement window.
module mfc_cycle_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_comb begin
        if (cnt == MAXV) begin
            cnt_next = MAXV;
        end else begin
            cnt_next = cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt_next;
        end
    end
endmodule

// File: rtl/mfc_ctrl.sv
`timescale 1ns/1ps
// Window controller: idle / arm / count.
module mfc_ctrl
    import mfc_pkg::*;
#(
    parameter int WIN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg,
    input  logic       rise,
    output mfc_state_e state,
    output logic       cnt_clr,
    output logic       cnt_inc,
    output logic       publish
);
    localparam int EW = $clog2(WIN + 1);
    localparam logic [EW-1:0] LAST = EW'(WIN - 1);

    mfc_state_e      state_nxt;
    logic [EW-1:0]   edges;
    logic            last_edge;

    assign last_edge = rise && (edges == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // slow-edge counter inside the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges <= '0;
        end else if (chg || state != ST_COUNT) begin
            edges <= '0;
        end else if (rise) begin
            edges <= edges + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (chg) state_nxt = ST_ARM;                  // start
            end
            ST_ARM: begin
                if (chg)       state_nxt = ST_ARM;            // restart
                else if (rise) state_nxt = ST_COUNT;          // open
            end
            ST_COUNT: begin
                if (chg)            state_nxt = ST_ARM;       // restart
                else if (last_edge) state_nxt = ST_IDLE;      // close
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        publish = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clr = chg;
            end
            ST_ARM: begin
                cnt_clr = 1'b1;
            end
            ST_COUNT: begin
                cnt_clr = chg;
                cnt_inc = !chg;
                publish = !chg && last_edge;
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/mfc_meter.sv
`timescale 1ns/1ps
// Main clock frequency counter, top level.
module mfc_meter
    import mfc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int WIN_PERIODS = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_main,
    input  logic             rst_n,
    input  logic             slow_clk,
    input  logic             clk_change,
    output logic [CNT_W:0]   status
);
    mfc_state_e        state;
    logic              slow_rise;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              publish;
    logic [CNT_W-1:0]  cyc_cnt;
    logic [CNT_W-1:0]  cyc_next;
    logic [CNT_W-1:0]  result_q;
    logic              ready_q;

    mfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_main),
        .rst_n    (rst_n),
        .async_in (slow_clk),
        .rise     (slow_rise)
    );

    mfc_ctrl #(.WIN(WIN_PERIODS)) u_ctrl (
        .clk     (clk_main),
        .rst_n   (rst_n),
        .chg     (clk_change),
        .rise    (slow_rise),
        .state   (state),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .publish (publish)
    );

    mfc_cycle_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk_main),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .cnt      (cyc_cnt),
        .cnt_next (cyc_next)
    );

    // result register: count and ready change together
    always_ff @(posedge clk_main or negedge rst_n) begin
        if (!rst_n) begin
            ready_q  <= 1'b0;
            result_q <= '0;
        end else if (clk_change) begin
            ready_q  <= 1'b0;
        end else if (publish) begin
            ready_q  <= 1'b1;
            result_q <= cyc_next;
        end
    end

    assign status = {ready_q, result_q};
endmodule

// File: rtl/mfc_meter_chk.sv
`timescale 1ns/1ps
module mfc_meter_chk
    import mfc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chg,
    input  logic [CNT_W:0]   status,
    input  mfc_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_inc
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (status == '0));

    p_ready_from_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[CNT_W]) |-> ($past(state) == ST_COUNT));

    p_change_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (!status[CNT_W] && state == ST_ARM));

    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(status[CNT_W]) |-> $stable(status[CNT_W-1:0]));

    p_single_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !chg) |=> (state == ST_IDLE && $stable(status)));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && state == ST_COUNT) |=> (state == ST_ARM && cnt == '0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && cnt_inc) |=> (cnt == MAXV));
endmodule

bind mfc_meter mfc_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk_main),
    .rst_n   (rst_n),
    .chg     (clk_change),
    .status  (status),
    .state   (state),
    .cnt     (cyc_cnt),
    .cnt_inc (cnt_inc)
);

// File: tb/mfc_meter_bench.sv
`timescale 1ns/1ps
module mfc_meter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 16;
    localparam int WATCHDOG   = 190000;

    logic        clk_main = 1'b0;
    logic        rst_n    = 1'b0;
    logic        slow_clk = 1'b0;
    logic        clk_change = 1'b0;
    logic [16:0] status;

    int checks = 0;
    int errors = 0;
    int slow_half = 40;
    int cycles = 0;
    bit done = 1'b0;

    mfc_meter u_mfc_meter (
        .clk_main   (clk_main),
        .rst_n      (rst_n),
        .slow_clk   (slow_clk),
        .clk_change (clk_change),
        .status     (status)
    );

    always #(CLK_PERIOD/2) clk_main = ~clk_main;

    initial begin
        #2;
        forever begin
            #(slow_half) slow_clk = ~slow_clk;
        end
    end

    always @(posedge clk_main) cycles <= cycles + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_main);
    endtask

    task automatic pulse_change();
        clk_change = 1'b1;
        @(negedge clk_main);
        clk_change = 1'b0;
    endtask

    // wait for ready; returns cycles waited, or -1 on timeout
    task automatic wait_ready(input int limit, output int waited);
        waited = -1;
        for (int i = 0; i < limit; i++) begin
            if (status[16]) begin
                waited = i;
                break;
            end
            @(negedge clk_main);
        end
    endtask

    task automatic measure(input int half, input string req);
        logic [15:0] old_cnt;
        int w;
        longint diff;
        slow_half = half;
        step((6 * half) / CLK_PERIOD + 10);
        old_cnt = status[15:0];
        pulse_change();
        chk(status[16] == 1'b0, "R4 ready cleared", status[16], 0);
        chk(status[15:0] == old_cnt, "R5 count held", status[15:0], old_cnt);
        wait_ready(40 * half / CLK_PERIOD + 200, w);
        chk(w >= 0, "R3 ready set", w, 1);
        // R2/R5: at the first ready sample the new count is already present
        diff = longint'(status[15:0]) * CLK_PERIOD - longint'(WIN * 2 * half);
        if (diff < 0) diff = -diff;
        chk(diff <= CLK_PERIOD, req, status[15:0], (WIN * 2 * half) / CLK_PERIOD);
    endtask

    initial begin
        int w;
        logic [16:0] snap;
        step(3);
        chk(status == 17'd0, "R1 status in reset", status, 0);
        rst_n = 1'b1;
        step(5);
        chk(status == 17'd0, "R1 status after reset", status, 0);
        step(60);
        chk(status == 17'd0, "R1 no measurement without change", status, 0);

        // ratio sweep (slow period / main period)
        measure(40,  "R2 ratio 8");
        measure(65,  "R2 ratio 13");
        measure(37,  "R2 ratio 7.4");
        measure(250, "R2 ratio 50");
        measure(500, "R2 ratio 100");
        measure(123, "R2 ratio 24.6");

        // single shot: status stays frozen
        snap = status;
        for (int k = 0; k < 3; k++) begin
            step(WIN * 2 * 123 / CLK_PERIOD);
            chk(status == snap, "R6 no retrigger", status, snap);
        end

        // abort and restart mid-window
        slow_half = 100;
        step(70);
        pulse_change();
        step(150);
        chk(status[16] == 1'b0, "R7 still measuring", status[16], 0);
        pulse_change();
        chk(status[16] == 1'b0, "R4 ready low after restart", status[16], 0);
        wait_ready(2000, w);
        chk(w >= WIN * 2 * 100 / CLK_PERIOD - 2, "R7 full window after restart", w, WIN * 2 * 100 / CLK_PERIOD);
        begin
            longint diff;
            diff = longint'(status[15:0]) * CLK_PERIOD - longint'(WIN * 2 * 100);
            if (diff < 0) diff = -diff;
            chk(diff <= CLK_PERIOD, "R7 restarted count", status[15:0], WIN * 2 * 100 / CLK_PERIOD);
        end

        // saturation: ratio 4200 exceeds 16-bit range over 16 periods
        slow_half = 21000;
        step(4300);
        pulse_change();
        wait_ready(80000, w);
        chk(w >= 0, "R3 ready after long window", w, 1);
        chk(status[15:0] == 16'hFFFF, "R8 saturated count", status[15:0], 16'hFFFF);

        done = 1'b1;
    end

    initial begin
        wait (done || cycles >= WATCHDOG);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule